// File: doc/BRIEF.md
# Display DMA Interrupt Status and Frame-ID Capture

This block gathers the interrupt events of a two-channel display DMA engine and turns them into a status register, a set of enable bits and one combined interrupt line. Each channel raises single-cycle pulses for five event kinds: start of frame, end of frame, branch, bus error and disable done. Each channel also presents the frame identifier word of the descriptor it is working on. When the block signals a frame-related interrupt, it also latches the frame identifier that belongs to that interrupt. Software can then tell which descriptor caused it.

With `dual_mode` low, only channel 0 takes part. With `dual_mode` high, a frame event counts only once both channels have reached it. The identifier stored is the one from the channel that got there last. A bus error is the exception: it is posted at once from whichever channel saw it. The capture register is sticky. It loads only when no other enabled interrupt is pending, so it keeps describing the first interrupt until software clears that interrupt. Software uses a small synchronous register bus with a registered read port.

Top module: `dirq_capture`

## Requirements
- R1: After a synchronous reset the status bits, the enable bits and the captured frame ID are all zero, and `irq_o` is low.
- R2: Status bit positions are: bit 0 disable done, bit 1 start of frame, bit 2 bus error, bit 3 end of frame, bit 4 branch. A posted event sets its bit on the clock edge where it is posted.
- R3: A write to address 0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. If an event is posted in the same cycle as the clear of its bit, the bit ends up set.
- R4: `irq_o` is high one cycle after a status bit is set that is either enabled or the bus-error bit. Bus error cannot be masked.
- R5: The frame ID is captured only for start of frame, end of frame, branch or bus error. The event must be enabled (bus error always is), and no enabled status bit may stay pending after that cycle's clear. If several events qualify together, the priority is bus error, then end of frame, then branch, then start of frame.
- R6: While an enabled status bit stays pending, the captured frame ID does not change.
- R7: In dual mode, a non-bus-error event is posted only once both channels have pulsed it. The ID comes from the channel that pulsed last; when both pulse in the same cycle, channel 1's ID is used.
- R8: In dual mode, a bus error pulse from either channel is posted in the same cycle, without waiting for the other channel.
- R9: In single mode, event pulses on channel 1 have no effect.
- R10: Register map: address 0 is status, address 1 is enables (bits 0, 1, 3, 4 are writable; bit 2 reads 0), address 2 is the captured ID in bits 31:3 with bits 2:0 reading 0. Writes to address 2 are ignored. Read data appears one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = both channels take part and frame events are joined |
| ch_done | input | 2 | Disable-done pulse, one bit per channel |
| ch_sof | input | 2 | Start-of-frame pulse per channel |
| ch_berr | input | 2 | Bus-error pulse per channel |
| ch_eof | input | 2 | End-of-frame pulse per channel |
| ch_bra | input | 2 | Branch pulse per channel |
| ch0_fid | input | FID_W | Frame ID of channel 0's current descriptor |
| ch1_fid | input | FID_W | Frame ID of channel 1's current descriptor |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its defaults: a 29-bit frame ID and five event kinds. This puts the ID exactly in bits 31:3 of the read word, so the position and the zero low bits of the ID register are checked. Small ID values let the bench see at once which channel's ID was taken. They cover a channel-1 win when both channels arrive in the same cycle, and both orders of arrival in dual mode.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int EV_N    = 5;
  localparam int EV_DONE = 0;
  localparam int EV_SOF  = 1;
  localparam int EV_BERR = 2;
  localparam int EV_EOF  = 3;
  localparam int EV_BRA  = 4;
  // event kinds that load the frame ID register
  localparam logic [EV_N-1:0] CAPTURE_SET = 5'b11110;
  // event kinds that ignore the enable bits
  localparam logic [EV_N-1:0] NOMASK_SET  = 5'b00100;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_ENABLE = 2'd1,
    RA_FID    = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dirq_evt_join.sv
module dirq_evt_join #(
  parameter int FID_W     = 29,
  parameter bit WAIT_BOTH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual,
  input  logic [1:0]       ev,
  input  logic [FID_W-1:0] fid0,
  input  logic [FID_W-1:0] fid1,
  output logic             post,
  output logic [FID_W-1:0] post_fid
);
  logic [1:0] seen_q;
  logic [1:0] arrived;

  assign arrived = seen_q | ev;

  generate
    if (WAIT_BOTH) begin : g_join
      always_comb begin
        if (!dual) begin
          post     = ev[0];
          post_fid = fid0;
        end else begin
          post     = &arrived;
          // channel that completes the pair is the last; tie goes to ch1
          post_fid = ev[1] ? fid1 : fid0;
        end
      end
      always_ff @(posedge clk) begin
        if (rst || !dual || post) seen_q <= 2'b00;
        else                      seen_q <= arrived;
      end
    end else begin : g_direct
      always_comb begin
        if (!dual) begin
          post     = ev[0];
          post_fid = fid0;
        end else begin
          post     = |ev;
          post_fid = ev[0] ? fid0 : fid1;
        end
      end
      assign seen_q = 2'b00;
    end
  endgenerate
endmodule

// File: rtl/dirq_id_pick.sv
module dirq_id_pick
  import dirq_pkg::*;
#(
  parameter int FID_W = 29
) (
  input  logic [EV_N-1:0]            cand,
  input  logic [EV_N-1:0][FID_W-1:0] fids,
  output logic                       hit,
  output logic [FID_W-1:0]           hit_fid
);
  always_comb begin
    hit     = 1'b1;
    hit_fid = fids[EV_BERR];
    if      (cand[EV_BERR]) hit_fid = fids[EV_BERR];
    else if (cand[EV_EOF])  hit_fid = fids[EV_EOF];
    else if (cand[EV_BRA])  hit_fid = fids[EV_BRA];
    else if (cand[EV_SOF])  hit_fid = fids[EV_SOF];
    else                    hit     = 1'b0;
  end
endmodule

// File: rtl/dirq_capture.sv
module dirq_capture
  import dirq_pkg::*;
#(
  parameter int FID_W = 29,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_mode,
  input  logic [1:0]       ch_done,
  input  logic [1:0]       ch_sof,
  input  logic [1:0]       ch_berr,
  input  logic [1:0]       ch_eof,
  input  logic [1:0]       ch_bra,
  input  logic [FID_W-1:0] ch0_fid,
  input  logic [FID_W-1:0] ch1_fid,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o
);
  localparam int PAD_W = DW - FID_W;

  logic [EV_N-1:0][1:0]       ev_in;
  logic [EV_N-1:0]            post;
  logic [EV_N-1:0][FID_W-1:0] post_fid;
  logic [EV_N-1:0]            status_q, enable_q, eff, clr, kept, cand;
  logic [FID_W-1:0]           fid_q, cap_fid;
  logic                       cap_hit, allow, wr_stat, wr_en;
  logic                       unused_wbits;

  assign ev_in[EV_DONE] = ch_done;
  assign ev_in[EV_SOF]  = ch_sof;
  assign ev_in[EV_BERR] = ch_berr;
  assign ev_in[EV_EOF]  = ch_eof;
  assign ev_in[EV_BRA]  = ch_bra;

  generate
    for (genvar k = 0; k < EV_N; k++) begin : g_ev
      dirq_evt_join #(
        .FID_W    (FID_W),
        .WAIT_BOTH(k != EV_BERR)
      ) u_join (
        .clk     (clk),
        .rst     (rst),
        .dual    (dual_mode),
        .ev      (ev_in[k]),
        .fid0    (ch0_fid),
        .fid1    (ch1_fid),
        .post    (post[k]),
        .post_fid(post_fid[k])
      );
    end
  endgenerate

  assign wr_stat = bus_sel && bus_we && (bus_addr == RA_STATUS);
  assign wr_en   = bus_sel && bus_we && (bus_addr == RA_ENABLE);
  assign clr     = wr_stat ? bus_wdata[EV_N-1:0] : '0;
  assign eff     = enable_q | NOMASK_SET;
  assign kept    = status_q & ~clr;
  assign allow   = ((kept & eff) == '0);
  assign cand    = allow ? (post & CAPTURE_SET & eff) : '0;
  assign unused_wbits = ^bus_wdata[DW-1:EV_N];

  dirq_id_pick #(.FID_W(FID_W)) u_pick (
    .cand   (cand),
    .fids   (post_fid),
    .hit    (cap_hit),
    .hit_fid(cap_fid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      fid_q    <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= kept | post;
      if (wr_en)   enable_q <= bus_wdata[EV_N-1:0] & ~NOMASK_SET;
      if (cap_hit) fid_q    <= cap_fid;
      irq_o <= |(status_q & eff);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      unique case (reg_addr_e'(bus_addr))
        RA_STATUS: bus_rdata <= {{(DW-EV_N){1'b0}}, status_q};
        RA_ENABLE: bus_rdata <= {{(DW-EV_N){1'b0}}, enable_q};
        RA_FID:    bus_rdata <= {fid_q, {PAD_W{1'b0}}};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dirq_capture_chk.sv
module dirq_capture_chk
  import dirq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            dual_mode,
  input logic [1:0]      ch_done,
  input logic [1:0]      ch_sof,
  input logic [1:0]      ch_berr,
  input logic [1:0]      ch_eof,
  input logic [1:0]      ch_bra,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [1:0]      bus_addr,
  input logic [EV_N-1:0] status_q,
  input logic [EV_N-1:0] enable_q,
  input logic [28:0]     fid_q,
  input logic            irq_o
);
  logic            stat_wr;
  logic            ch0_any;
  logic [EV_N-1:0] live;

  assign stat_wr = bus_sel && bus_we && (bus_addr == 2'd0);
  assign ch0_any = ch_done[0] | ch_sof[0] | ch_berr[0] | ch_eof[0] | ch_bra[0];
  assign live    = status_q & (enable_q | NOMASK_SET);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (status_q == '0 && fid_q == '0 && !irq_o));

  p_irq_up_r4: assert property (@(posedge clk) disable iff (rst)
    (live != '0) |=> irq_o);

  p_irq_down_r4: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |=> !irq_o);

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ((live != '0) && !stat_wr) |=> $stable(fid_q));

  p_berr_now_r8: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && (ch_berr != 2'b00)) |=> status_q[EV_BERR]);

  p_ch1_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !ch0_any && !stat_wr) |=> $stable(status_q));
endmodule

bind dirq_capture dirq_capture_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .dual_mode(dual_mode),
  .ch_done  (ch_done),
  .ch_sof   (ch_sof),
  .ch_berr  (ch_berr),
  .ch_eof   (ch_eof),
  .ch_bra   (ch_bra),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .status_q (status_q),
  .enable_q (enable_q),
  .fid_q    (fid_q),
  .irq_o    (irq_o)
);

// File: tb/dirq_capture_test.sv
module dirq_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dual_mode = 1'b0;
  logic [1:0]  ch_done = '0, ch_sof = '0, ch_berr = '0, ch_eof = '0, ch_bra = '0;
  logic [28:0] ch0_fid = '0, ch1_fid = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dirq_capture uut (
    .clk(clk), .rst(rst), .dual_mode(dual_mode),
    .ch_done(ch_done), .ch_sof(ch_sof), .ch_berr(ch_berr),
    .ch_eof(ch_eof), .ch_bra(ch_bra),
    .ch0_fid(ch0_fid), .ch1_fid(ch1_fid),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       dual;
    logic [1:0] sof, eof, bra, berr, done;
    logic [7:0] f0, f1;
    logic [4:0] clr;
    logic [4:0] es;
    logic [7:0] eid;
    logic       eirq;
  } vec_t;

  function automatic vec_t mk(logic d, logic [1:0] s, logic [1:0] e, logic [1:0] b,
                              logic [1:0] be, logic [1:0] dn, logic [7:0] a0,
                              logic [7:0] a1, logic [4:0] c, logic [4:0] xs,
                              logic [7:0] xi, logic xq);
    vec_t v;
    v.dual = d; v.sof = s; v.eof = e; v.bra = b; v.berr = be; v.done = dn;
    v.f0 = a0; v.f1 = a1; v.clr = c; v.es = xs; v.eid = xi; v.eirq = xq;
    return v;
  endfunction

  // dual sof eof bra berr done f0 f1 clr | status id irq   (all enables on)
  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    mk(0,2'b01,0,0,0,0,8'h11,0,5'h00, 5'h02,8'h11,1), // R2 R5 first capture
    mk(0,0,2'b01,0,0,0,8'h22,0,5'h00, 5'h0A,8'h11,1), // R6 sticky
    mk(0,0,0,0,0,0,0,0,5'h02,          5'h08,8'h11,1), // R3 clear one bit
    mk(0,0,0,2'b01,0,0,8'h33,0,5'h08, 5'h10,8'h33,1), // R3 R5 event beats clear
    mk(0,0,0,0,0,0,0,0,5'h10,          5'h00,8'h33,0), // R4 irq drops
    mk(1,2'b01,0,0,0,0,8'h44,0,5'h00, 5'h00,8'h33,0), // R7 waits for ch1
    mk(1,2'b10,0,0,0,0,0,8'h55,5'h00, 5'h02,8'h55,1), // R7 ch1 last
    mk(1,0,0,0,0,0,0,0,5'h02,          5'h00,8'h55,0),
    mk(1,0,0,0,2'b10,0,0,8'h66,5'h00, 5'h04,8'h66,1), // R8 immediate
    mk(1,0,0,0,0,0,0,0,5'h04,          5'h00,8'h66,0),
    mk(1,0,2'b11,0,0,0,8'h77,8'h78,5'h00, 5'h08,8'h78,1), // R7 tie -> ch1
    mk(1,0,0,0,0,0,0,0,5'h08,          5'h00,8'h78,0),
    mk(1,0,2'b10,0,0,0,0,8'h80,5'h00, 5'h00,8'h78,0), // R7 ch1 first
    mk(1,0,2'b01,0,0,0,8'h81,0,5'h00, 5'h08,8'h81,1), // R7 ch0 last
    mk(1,0,0,0,0,0,0,0,5'h08,          5'h00,8'h81,0),
    mk(0,0,0,0,0,2'b01,0,0,5'h00,      5'h01,8'h81,1), // R5 done not captured
    mk(0,2'b01,0,0,0,0,8'h90,0,5'h00, 5'h03,8'h81,1), // R5 blocked by pending
    mk(0,0,0,0,0,0,0,0,5'h03,          5'h00,8'h81,0),
    mk(0,2'b10,0,0,0,0,0,8'h95,5'h00, 5'h00,8'h81,0)  // R9 ch1 ignored
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic quiet();
    ch_done = '0; ch_sof = '0; ch_berr = '0; ch_eof = '0; ch_bra = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd1, d); chk("R1 enable", d, 32'h0);
    rd(2'd2, d); chk("R1 fid", d, 32'h0);

    // R10 enable map: bit 2 not stored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 enable readback", d, 32'h1B);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      dual_mode = v.dual;
      ch_sof = v.sof; ch_eof = v.eof; ch_bra = v.bra;
      ch_berr = v.berr; ch_done = v.done;
      ch0_fid = {21'b0, v.f0}; ch1_fid = {21'b0, v.f1};
      if (v.clr != '0) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = {27'b0, v.clr};
      end
      @(negedge clk);
      quiet();
      rd(2'd0, d);
      chk($sformatf("row %0d status R2 R3 R7 R8 R9", i), d, {27'b0, v.es});
      chk($sformatf("row %0d irq R4", i), {31'b0, irq_o}, {31'b0, v.eirq});
      rd(2'd2, d);
      chk($sformatf("row %0d fid R5 R6 R7 R10", i), d, {21'b0, v.eid, 3'b000});
    end

    // R4 R5: masked event sets status but neither captures nor interrupts
    dual_mode = 1'b0;
    wr(2'd1, 32'h0);
    ch_sof = 2'b01; ch0_fid = 29'h0A0;
    @(negedge clk); quiet();
    rd(2'd0, d); chk("R4 masked status", d, 32'h02);
    chk("R4 masked irq", {31'b0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R5 masked no capture", d, {21'b0, 8'h81, 3'b000});

    // R4 R5: bus error ignores enables, captures
    ch_berr = 2'b01; ch0_fid = 29'h0A1;
    @(negedge clk); quiet();
    rd(2'd0, d); chk("R2 berr status", d, 32'h06);
    chk("R4 berr irq", {31'b0, irq_o}, 32'h1);
    rd(2'd2, d); chk("R5 berr capture", d, {21'b0, 8'hA1, 3'b000});

    // R3 writing zeros clears nothing
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R3 zero write", d, 32'h06);

    // R10 write to ID register ignored
    wr(2'd2, 32'hFFFF_FFF8);
    rd(2'd2, d); chk("R10 fid write ignored", d, {21'b0, 8'hA1, 3'b000});

    // R1 reset in mid-run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(2'd0, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule